// File: doc/BRIEF.md
# Four-Beat Burst SRAM with Independent Read and Write Ports

This block is a synchronous memory whose read side and write side each have their own command, address and data buses, so a read and a write can be issued in the same clock. All transfers move in bursts of four beats. The controller clock carries two beats per cycle: one on a rising-phase lane and one on a falling-phase lane. A burst therefore occupies its port for two clocks. Each address selects one array word, and that word is four beats wide. The write side collects the four incoming beats and their per-beat byte enables into one wide word. It then commits that word to the array in a single masked write. The read side fetches one wide word and presents it in two clocks, two beats per clock, while a valid flag is high.

Read data always reflects every write accepted before the read. This holds even when the write is still being collected or is waiting to be committed. The pending bytes are merged over the array contents on the way out, so no stall is ever needed. A synchronous active-high reset empties both pipelines and the output stage. It does not clear the array contents.

Top module: `quad_burst_sram`

## Requirements
- R1: A write burst is accepted when wr_req is high and the write port is idle. In that cycle, the rise lane carries beat 0 and the fall lane carries beat 1. In the following cycle, the rise lane carries beat 2 and the fall lane carries beat 3. Beat b is stored at word bits [b*BEAT_W +: BEAT_W], and all four beats reach the array together.
- R2: A read is accepted when rd_req is high and the read port is idle. The read is sampled in cycle R. Beats 0 and 1 appear on the rise and fall lanes in cycle R+2, and beats 2 and 3 appear in cycle R+3.
- R3: rd_valid is high only in cycles that present burst beats. Both read lanes are zero whenever rd_valid is low.
- R4: The byte enables travel with the data lane of the same cycle. Bit j of an enable lane covers bits [8j+7:8j] of that lane's beat. A 1 writes the byte, and a 0 keeps the byte's previous contents.
- R5: A read and a write may be accepted in the same cycle at different addresses. Each one completes exactly as it would alone.
- R6: On each port, a request raised in the cycle after an accepted request is ignored. An ignored read produces no burst. An ignored write changes no array location.
- R7: A read to the same address, accepted in the same cycle as a write, returns the bytes of that write merged over the old word.
- R8: A read to the same address, accepted one cycle after a write was accepted, returns the bytes of that write merged over the old word.
- R9: A read accepted one cycle before a write to the same address returns the old word.
- R10: Reads accepted every two cycles produce a continuous rd_valid, with the bursts in order.
- R11: Reset drops rd_valid within one clock and discards a read in flight. It also discards a write still being collected, so that write never reaches the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read burst request |
| rd_addr | input | ADDR_W | Word address of the read |
| wr_req | input | 1 | Write burst request |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data_rise | input | BEAT_W | Write beat on the rising phase (beat 0 or 2) |
| wr_data_fall | input | BEAT_W | Write beat on the falling phase (beat 1 or 3) |
| wr_be_rise | input | BEAT_W/8 | Byte enables for the rise-lane beat |
| wr_be_fall | input | BEAT_W/8 | Byte enables for the fall-lane beat |
| rd_data_rise | output | BEAT_W | Read beat on the rising phase (beat 0 or 2) |
| rd_data_fall | output | BEAT_W | Read beat on the falling phase (beat 1 or 3) |
| rd_valid | output | 1 | High while read beats are presented |

## Verification
The bench targets the coherency windows around a write. It covers reads issued one cycle before, in the same cycle as, and one cycle after a write to the same address.

- A design that skips the merge from the collection stage would return stale beats for the same-cycle read.
- A design that ignores the pending-commit stage would fail the read one cycle after the write.
- A design that merges too eagerly would leak new data into the read issued just before the write.

Partial byte masks in different beats expose enables latched with the command instead of with each beat. Requests raised on a busy port, and a reset landing mid-burst, expose a design that restarts bursts or commits half-collected words.

// File: rtl/sq4_pkg.sv
`timescale 1ns/1ps
package sq4_pkg;

    localparam int SQ_BEAT_W  = 16;
    localparam int SQ_ADDR_W  = 4;
    localparam int SQ_BYTE_W  = 8;
    localparam int SQ_BEATS   = 4;
    localparam int SQ_LANES   = 2;

    typedef enum logic {
        COL_IDLE = 1'b0,
        COL_HALF = 1'b1
    } col_phase_e;

    typedef enum logic {
        OUT_FIRST  = 1'b0,
        OUT_SECOND = 1'b1
    } out_phase_e;

endpackage

// File: rtl/sq4_wr_collect.sv
`timescale 1ns/1ps
module sq4_wr_collect
    import sq4_pkg::*;
#(
    parameter int BEAT_W = SQ_BEAT_W,
    parameter int ADDR_W = SQ_ADDR_W,
    localparam int NB     = BEAT_W / SQ_BYTE_W,
    localparam int LANE_W = SQ_LANES * BEAT_W,
    localparam int WORD_W = SQ_BEATS * BEAT_W,
    localparam int MASK_W = SQ_BEATS * NB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BEAT_W-1:0] d_rise,
    input  logic [BEAT_W-1:0] d_fall,
    input  logic [NB-1:0]     be_rise,
    input  logic [NB-1:0]     be_fall,
    output logic              col_active,
    output logic [ADDR_W-1:0] col_addr,
    output logic [WORD_W-1:0] col_word,
    output logic [MASK_W-1:0] col_mask,
    output logic              cm_valid,
    output logic [ADDR_W-1:0] cm_addr,
    output logic [WORD_W-1:0] cm_word,
    output logic [MASK_W-1:0] cm_mask
);

    col_phase_e                phase;
    logic [LANE_W-1:0]         lo_data;
    logic [SQ_LANES*NB-1:0]    lo_mask;

    // Second half of the burst arrives live; expose the full word so the
    // read side can merge a write that is still being collected.
    assign col_active = (phase == COL_HALF);
    assign col_word   = {d_fall, d_rise, lo_data};
    assign col_mask   = {be_fall, be_rise, lo_mask};

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= COL_IDLE;
            cm_valid <= 1'b0;
        end else begin
            cm_valid <= 1'b0;
            unique case (phase)
                COL_IDLE: begin
                    if (wr_req) begin
                        phase    <= COL_HALF;
                        col_addr <= wr_addr;
                        lo_data  <= {d_fall, d_rise};
                        lo_mask  <= {be_fall, be_rise};
                    end
                end
                COL_HALF: begin
                    phase    <= COL_IDLE;
                    cm_valid <= 1'b1;
                    cm_addr  <= col_addr;
                    cm_word  <= col_word;
                    cm_mask  <= col_mask;
                end
                default: phase <= COL_IDLE;
            endcase
        end
    end

    // R1: an accepted write reaches the commit stage two clocks later
    p_commit_two_r1: assert property (@(posedge clk) disable iff (rst)
        (phase == COL_IDLE && wr_req) |=> ##1 cm_valid);

    // R1: the committed address is the one sampled with the command
    p_commit_addr_r1: assert property (@(posedge clk) disable iff (rst)
        cm_valid |-> (cm_addr == $past(wr_addr, 2)));

    // R6: no commit ever follows directly on another commit
    p_commit_spacing_r6: assert property (@(posedge clk) disable iff (rst)
        cm_valid |=> !cm_valid);

endmodule

// File: rtl/sq4_word_array.sv
`timescale 1ns/1ps
module sq4_word_array
    import sq4_pkg::*;
#(
    parameter int ADDR_W = SQ_ADDR_W,
    parameter int WORD_W = SQ_BEATS * SQ_BEAT_W,
    localparam int MASK_W = WORD_W / SQ_BYTE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [MASK_W-1:0] wr_mask,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word
);

    logic [WORD_W-1:0] mem [DEPTH];

    // One wide masked write per committed burst
    always_ff @(posedge clk) begin
        if (we) begin
            for (int i = 0; i < MASK_W; i++) begin
                if (wr_mask[i]) begin
                    mem[wr_addr][i*SQ_BYTE_W +: SQ_BYTE_W] <= wr_word[i*SQ_BYTE_W +: SQ_BYTE_W];
                end
            end
        end
    end

    assign rd_word = mem[rd_addr];

endmodule

// File: rtl/sq4_beat_route.sv
`timescale 1ns/1ps
module sq4_beat_route
    import sq4_pkg::*;
#(
    parameter int BEAT_W = SQ_BEAT_W,
    localparam int WORD_W = SQ_BEATS * BEAT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    output logic [BEAT_W-1:0] rd_data_rise,
    output logic [BEAT_W-1:0] rd_data_fall,
    output logic              rd_valid
);

    logic              out_v;
    out_phase_e        out_ph;
    logic [WORD_W-1:0] out_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_v  <= 1'b0;
            out_ph <= OUT_FIRST;
        end else if (load) begin
            out_v    <= 1'b1;
            out_ph   <= OUT_FIRST;
            out_word <= load_word;
        end else if (out_v && out_ph == OUT_FIRST) begin
            out_ph <= OUT_SECOND;
        end else begin
            out_v  <= 1'b0;
            out_ph <= OUT_FIRST;
        end
    end

    always_comb begin
        rd_data_rise = '0;
        rd_data_fall = '0;
        if (out_v) begin
            if (out_ph == OUT_SECOND) begin
                rd_data_rise = out_word[2*BEAT_W +: BEAT_W];
                rd_data_fall = out_word[3*BEAT_W +: BEAT_W];
            end else begin
                rd_data_rise = out_word[0 +: BEAT_W];
                rd_data_fall = out_word[BEAT_W +: BEAT_W];
            end
        end
    end

    assign rd_valid = out_v;

    // R3: every burst presents its second pair of beats
    p_burst_pair_r3: assert property (@(posedge clk) disable iff (rst)
        (out_v && out_ph == OUT_FIRST && !load) |=> (out_v && out_ph == OUT_SECOND));

endmodule

// File: rtl/sq4_rd_path.sv
`timescale 1ns/1ps
module sq4_rd_path
    import sq4_pkg::*;
#(
    parameter int BEAT_W = SQ_BEAT_W,
    parameter int ADDR_W = SQ_ADDR_W,
    localparam int WORD_W = SQ_BEATS * BEAT_W,
    localparam int MASK_W = WORD_W / SQ_BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] look_addr,
    input  logic [WORD_W-1:0] arr_word,
    input  logic              cm_valid,
    input  logic [ADDR_W-1:0] cm_addr,
    input  logic [WORD_W-1:0] cm_word,
    input  logic [MASK_W-1:0] cm_mask,
    input  logic              col_active,
    input  logic [ADDR_W-1:0] col_addr,
    input  logic [WORD_W-1:0] col_word,
    input  logic [MASK_W-1:0] col_mask,
    output logic              load,
    output logic [WORD_W-1:0] merged
);

    logic              s1_v;
    logic              accept;
    logic              cm_hit;
    logic              col_hit;
    logic [WORD_W-1:0] mid;

    assign accept = rd_req && !s1_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v <= 1'b0;
        end else begin
            s1_v <= accept;
            if (accept) begin
                look_addr <= rd_addr;
            end
        end
    end

    assign cm_hit  = cm_valid   && (cm_addr  == look_addr);
    assign col_hit = col_active && (col_addr == look_addr);

    // Older pending commit first, then the younger burst under collection
    for (genvar gi = 0; gi < MASK_W; gi++) begin : g_merge
        assign mid[gi*SQ_BYTE_W +: SQ_BYTE_W] =
            (cm_hit && cm_mask[gi]) ? cm_word[gi*SQ_BYTE_W +: SQ_BYTE_W]
                                    : arr_word[gi*SQ_BYTE_W +: SQ_BYTE_W];
        assign merged[gi*SQ_BYTE_W +: SQ_BYTE_W] =
            (col_hit && col_mask[gi]) ? col_word[gi*SQ_BYTE_W +: SQ_BYTE_W]
                                      : mid[gi*SQ_BYTE_W +: SQ_BYTE_W];
    end

    assign load = s1_v;

    // R6: at most one read accepted per two clocks
    p_read_spacing_r6: assert property (@(posedge clk) disable iff (rst)
        s1_v |=> !s1_v);

endmodule

// File: rtl/quad_burst_sram.sv
`timescale 1ns/1ps
module quad_burst_sram
    import sq4_pkg::*;
#(
    parameter int BEAT_W = SQ_BEAT_W,
    parameter int ADDR_W = SQ_ADDR_W,
    localparam int NB     = BEAT_W / SQ_BYTE_W,
    localparam int WORD_W = SQ_BEATS * BEAT_W,
    localparam int MASK_W = SQ_BEATS * NB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BEAT_W-1:0] wr_data_rise,
    input  logic [BEAT_W-1:0] wr_data_fall,
    input  logic [NB-1:0]     wr_be_rise,
    input  logic [NB-1:0]     wr_be_fall,
    output logic [BEAT_W-1:0] rd_data_rise,
    output logic [BEAT_W-1:0] rd_data_fall,
    output logic              rd_valid
);

    logic              col_active;
    logic [ADDR_W-1:0] col_addr;
    logic [WORD_W-1:0] col_word;
    logic [MASK_W-1:0] col_mask;
    logic              cm_valid;
    logic [ADDR_W-1:0] cm_addr;
    logic [WORD_W-1:0] cm_word;
    logic [MASK_W-1:0] cm_mask;
    logic [ADDR_W-1:0] look_addr;
    logic [WORD_W-1:0] arr_word;
    logic              load;
    logic [WORD_W-1:0] merged;

    sq4_wr_collect #(.BEAT_W(BEAT_W), .ADDR_W(ADDR_W)) u_wr (
        .clk        (clk),
        .rst        (rst),
        .wr_req     (wr_req),
        .wr_addr    (wr_addr),
        .d_rise     (wr_data_rise),
        .d_fall     (wr_data_fall),
        .be_rise    (wr_be_rise),
        .be_fall    (wr_be_fall),
        .col_active (col_active),
        .col_addr   (col_addr),
        .col_word   (col_word),
        .col_mask   (col_mask),
        .cm_valid   (cm_valid),
        .cm_addr    (cm_addr),
        .cm_word    (cm_word),
        .cm_mask    (cm_mask)
    );

    sq4_word_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_arr (
        .clk     (clk),
        .we      (cm_valid),
        .wr_addr (cm_addr),
        .wr_word (cm_word),
        .wr_mask (cm_mask),
        .rd_addr (look_addr),
        .rd_word (arr_word)
    );

    sq4_rd_path #(.BEAT_W(BEAT_W), .ADDR_W(ADDR_W)) u_rd (
        .clk        (clk),
        .rst        (rst),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .look_addr  (look_addr),
        .arr_word   (arr_word),
        .cm_valid   (cm_valid),
        .cm_addr    (cm_addr),
        .cm_word    (cm_word),
        .cm_mask    (cm_mask),
        .col_active (col_active),
        .col_addr   (col_addr),
        .col_word   (col_word),
        .col_mask   (col_mask),
        .load       (load),
        .merged     (merged)
    );

    sq4_beat_route #(.BEAT_W(BEAT_W)) u_out (
        .clk          (clk),
        .rst          (rst),
        .load         (load),
        .load_word    (merged),
        .rd_data_rise (rd_data_rise),
        .rd_data_fall (rd_data_fall),
        .rd_valid     (rd_valid)
    );

    // R2: a burst that starts fresh was requested two clocks earlier
    p_read_latency_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid) |-> $past(rd_req, 2));

endmodule

// File: tb/quad_burst_sram_tb.sv
`timescale 1ns/1ps
module quad_burst_sram_tb;

    localparam int BW = 16;
    localparam int AW = 4;
    localparam int NB = BW / 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          wr_req;
    logic [AW-1:0] wr_addr;
    logic [BW-1:0] wr_data_rise, wr_data_fall;
    logic [NB-1:0] wr_be_rise, wr_be_fall;
    logic [BW-1:0] rd_data_rise, rd_data_fall;
    logic          rd_valid;

    int checks = 0;
    int errors = 0;
    logic [63:0] model [16];

    always #4 clk = ~clk;

    quad_burst_sram #(.BEAT_W(BW), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst),
        .rd_req(rd_req), .rd_addr(rd_addr),
        .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_data_rise(wr_data_rise), .wr_data_fall(wr_data_fall),
        .wr_be_rise(wr_be_rise), .wr_be_fall(wr_be_fall),
        .rd_data_rise(rd_data_rise), .rd_data_fall(rd_data_fall),
        .rd_valid(rd_valid)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] merge(input logic [63:0] old, input logic [63:0] w, input logic [7:0] m);
        logic [63:0] r = old;
        for (int i = 0; i < 8; i++) if (m[i]) r[i*8 +: 8] = w[i*8 +: 8];
        return r;
    endfunction

    task automatic idle(input int n);
        rd_req = 0; wr_req = 0;
        wr_data_rise = '0; wr_data_fall = '0; wr_be_rise = '0; wr_be_fall = '0;
        repeat (n) @(negedge clk);
    endtask

    // Called just after a negedge; occupies two cycles of the write port.
    task automatic wr_burst(input logic [AW-1:0] a, input logic [63:0] w, input logic [7:0] m);
        wr_req = 1; wr_addr = a;
        wr_data_rise = w[15:0];  wr_data_fall = w[31:16];
        wr_be_rise = m[1:0];     wr_be_fall = m[3:2];
        @(negedge clk);
        wr_req = 0;
        wr_data_rise = w[47:32]; wr_data_fall = w[63:48];
        wr_be_rise = m[5:4];     wr_be_fall = m[7:6];
        @(negedge clk);
        wr_data_rise = '0; wr_data_fall = '0; wr_be_rise = '0; wr_be_fall = '0;
    endtask

    // Called just after a negedge; checks beats in cycles R+2 and R+3.
    task automatic rd_burst(input logic [AW-1:0] a, input logic [63:0] e, input string tag);
        rd_req = 1; rd_addr = a;
        @(negedge clk);
        rd_req = 0;
        @(negedge clk);
        chk(rd_valid && {rd_data_fall, rd_data_rise} == e[31:0], {tag, " beats01"},
            {31'd0, rd_valid, rd_data_fall, rd_data_rise}, {32'd1, e[31:0]});
        @(negedge clk);
        chk(rd_valid && {rd_data_fall, rd_data_rise} == e[63:32], {tag, " beats23"},
            {31'd0, rd_valid, rd_data_fall, rd_data_rise}, {32'd1, e[63:32]});
    endtask

    task automatic t_reset;
        rst = 1; idle(3);
        chk(!rd_valid && rd_data_rise == 0 && rd_data_fall == 0, "R11 R3 reset quiet",
            {31'd0, rd_valid, rd_data_fall, rd_data_rise}, 64'd0);
        rst = 0; idle(1);
    endtask

    task automatic t_fill;
        for (int a = 0; a < 16; a++) begin
            logic [63:0] w;
            w = {16'hC300 + 16'(a), 16'h8200 + 16'(a), 16'h4100 + 16'(a), 16'h1000 + 16'(a)};
            wr_burst(AW'(a), w, 8'hFF);
            model[a] = w;
        end
        idle(2);
        rd_burst(4'd3, model[3], "R1 R2 fill addr3");
        idle(1);
        chk(!rd_valid && rd_data_rise == 0 && rd_data_fall == 0, "R3 idle after burst",
            {31'd0, rd_valid, rd_data_fall, rd_data_rise}, 64'd0);
        rd_burst(4'd12, model[12], "R1 R2 fill addr12");
        idle(2);
    endtask

    task automatic t_mask;
        logic [63:0] w = 64'hDEAD_BEEF_CAFE_F00D;
        logic [7:0]  m = 8'b1001_0110;
        wr_burst(4'd5, w, m);
        model[5] = merge(model[5], w, m);
        idle(2);
        rd_burst(4'd5, model[5], "R4 per-beat mask");
        idle(2);
    endtask

    task automatic t_concurrent;
        logic [63:0] w = 64'h1111_2222_3333_4444;
        logic [63:0] old9 = model[9];
        fork
            wr_burst(4'd7, w, 8'hFF);
            rd_burst(4'd9, old9, "R5 read beside write");
        join
        model[7] = w;
        idle(2);
        rd_burst(4'd7, model[7], "R5 write beside read landed");
        idle(2);
    endtask

    task automatic t_coh_same;
        logic [63:0] w = 64'hA5A5_5A5A_0F0F_F0F0;
        logic [7:0]  m = 8'b0110_1101;
        logic [63:0] e = merge(model[2], w, m);
        fork
            wr_burst(4'd2, w, m);
            rd_burst(4'd2, e, "R7 same-cycle coherency");
        join
        model[2] = e;
        idle(2);
    endtask

    task automatic t_coh_next;
        logic [63:0] w = 64'h7777_8888_9999_AAAA;
        logic [7:0]  m = 8'b1010_0011;
        logic [63:0] e = merge(model[4], w, m);
        fork
            wr_burst(4'd4, w, m);
            begin @(negedge clk); rd_burst(4'd4, e, "R8 next-cycle coherency"); end
        join
        model[4] = e;
        idle(2);
    endtask

    task automatic t_old;
        logic [63:0] w = 64'h0102_0304_0506_0708;
        logic [63:0] old6 = model[6];
        fork
            rd_burst(4'd6, old6, "R9 read before write");
            begin @(negedge clk); wr_burst(4'd6, w, 8'hFF); end
        join
        model[6] = w;
        idle(2);
        rd_burst(4'd6, model[6], "R9 later read sees write");
        idle(2);
    endtask

    task automatic t_b2b;
        rd_req = 1; rd_addr = 4'd10;
        @(negedge clk); rd_req = 0;
        @(negedge clk); rd_req = 1; rd_addr = 4'd11;
        chk(rd_valid && {rd_data_fall, rd_data_rise} == model[10][31:0], "R10 first 01",
            {31'd0, rd_valid, rd_data_fall, rd_data_rise}, {32'd1, model[10][31:0]});
        @(negedge clk); rd_req = 0;
        chk(rd_valid && {rd_data_fall, rd_data_rise} == model[10][63:32], "R10 first 23",
            {31'd0, rd_valid, rd_data_fall, rd_data_rise}, {32'd1, model[10][63:32]});
        @(negedge clk);
        chk(rd_valid && {rd_data_fall, rd_data_rise} == model[11][31:0], "R10 second 01",
            {31'd0, rd_valid, rd_data_fall, rd_data_rise}, {32'd1, model[11][31:0]});
        @(negedge clk);
        chk(rd_valid && {rd_data_fall, rd_data_rise} == model[11][63:32], "R10 second 23",
            {31'd0, rd_valid, rd_data_fall, rd_data_rise}, {32'd1, model[11][63:32]});
        @(negedge clk);
        chk(!rd_valid && rd_data_rise == 0 && rd_data_fall == 0, "R3 quiet after chain",
            {31'd0, rd_valid, rd_data_fall, rd_data_rise}, 64'd0);
        idle(2);
    endtask

    task automatic t_ignore_rd;
        rd_req = 1; rd_addr = 4'd13;
        @(negedge clk); rd_addr = 4'd14;
        @(negedge clk); rd_req = 0;
        chk({rd_data_fall, rd_data_rise} == model[13][31:0], "R6 busy read 01",
            {32'd0, rd_data_fall, rd_data_rise}, {32'd0, model[13][31:0]});
        @(negedge clk);
        chk({rd_data_fall, rd_data_rise} == model[13][63:32], "R6 busy read 23",
            {32'd0, rd_data_fall, rd_data_rise}, {32'd0, model[13][63:32]});
        @(negedge clk);
        chk(!rd_valid, "R6 ignored read makes no burst", {63'd0, rd_valid}, 64'd0);
        idle(2);
    endtask

    task automatic t_ignore_wr;
        logic [63:0] w = 64'hBBBB_CCCC_DDDD_EEEE;
        wr_req = 1; wr_addr = 4'd0;
        wr_data_rise = w[15:0];  wr_data_fall = w[31:16];
        wr_be_rise = '1; wr_be_fall = '1;
        @(negedge clk);
        wr_addr = 4'd1;
        wr_data_rise = w[47:32]; wr_data_fall = w[63:48];
        @(negedge clk);
        idle(2);
        model[0] = w;
        rd_burst(4'd1, model[1], "R6 ignored write left addr1");
        idle(1);
        rd_burst(4'd0, model[0], "R6 accepted write landed");
        idle(2);
    endtask

    task automatic t_reset_mid;
        logic [63:0] w = 64'h9999_9999_9999_9999;
        wr_req = 1; wr_addr = 4'd8;
        wr_data_rise = w[15:0]; wr_data_fall = w[31:16];
        wr_be_rise = '1; wr_be_fall = '1;
        rd_req = 1; rd_addr = 4'd15;
        @(negedge clk);
        wr_req = 0; rd_req = 0; rst = 1;
        wr_data_rise = w[47:32]; wr_data_fall = w[63:48];
        @(negedge clk);
        rst = 0;
        chk(!rd_valid, "R11 read in flight dropped", {63'd0, rd_valid}, 64'd0);
        idle(1);
        chk(!rd_valid, "R11 still no burst", {63'd0, rd_valid}, 64'd0);
        idle(2);
        rd_burst(4'd8, model[8], "R11 half write discarded");
        idle(2);
    endtask

    initial begin
        rst = 1; rd_req = 0; rd_addr = '0; wr_req = 0; wr_addr = '0;
        wr_data_rise = '0; wr_data_fall = '0; wr_be_rise = '0; wr_be_fall = '0;
        @(negedge clk);
        t_reset;
        t_fill;
        t_mask;
        t_concurrent;
        t_coh_same;
        t_coh_next;
        t_old;
        t_b2b;
        t_ignore_rd;
        t_ignore_wr;
        t_reset_mid;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule